// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where each ALU operand of a five-stage in-order pipeline comes from while the consuming instruction sits in the execute stage. The choice is made before the ALU computes. It compares the consumer's two source register numbers against the destinations of the two older instructions still in flight. The older instruction one stage ahead holds the execute/memory result. The one two stages ahead holds the memory/writeback result.

The unit is purely combinational. An instruction-class input sets which operands are eligible for forwarding. Register-register and branch instructions may forward both operands. Load, store and immediate instructions may forward only the first operand. The reserved class forwards nothing. A stage is a candidate only when its write enable is set and its destination is not register 0. When both stages hold the same register, the newer execute/memory value is chosen.

Top module: `fwd_unit`

## Requirements
- R1: For class 2'b00 (register-register), an operand whose register equals the execute/memory destination, with that stage's write enable set and a nonzero destination, gets select 2'b10.
- R2: An operand that matches only a writing, nonzero memory/writeback destination gets select 2'b01.
- R3: When an eligible operand matches both writing, nonzero stage destinations, its select is 2'b10: the execute/memory stage wins.
- R4: A stage whose write enable is low never causes forwarding, even when its destination matches.
- R5: A destination of register 0 never causes forwarding from either stage.
- R6: For class 2'b01 (load, store, immediate), the second operand select is always 2'b00. The first operand follows R1 to R3.
- R7: For class 2'b10 (branch), both compared operands are checked as in R1 to R3.
- R8: For class 2'b11 (reserved), both selects are 2'b00.
- R9: An eligible operand with no matching candidate stage gets select 2'b00 (register file).
- R10: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | REG_W | First source register of the consumer |
| src_b_i | input | REG_W | Second source register of the consumer |
| cls_i | input | 2 | Instruction class: 00 reg-reg, 01 ld/st/imm, 10 branch, 11 reserved |
| exm_dst_i | input | REG_W | Destination register held in execute/memory |
| exm_wen_i | input | 1 | Register write enable of execute/memory |
| mwb_dst_i | input | REG_W | Destination register held in memory/writeback |
| mwb_wen_i | input | 1 | Register write enable of memory/writeback |
| sel_a_o | output | 2 | First operand source: 00 regfile, 10 exe/mem, 01 mem/wb |
| sel_b_o | output | 2 | Second operand source, same encoding |

## Verification
Two functions can fall in the same cycle: a match from the execute/memory stage and a match from the memory/writeback stage on the same operand. The class mask can also cancel a match on the second operand in that same cycle. The bench provokes these overlaps in two ways. Directed cases repeat one destination register across back-to-back writers. Random cases draw register numbers from a tiny range so collisions are frequent. Every result is judged against a bench function built from the priority and class rules.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;

  typedef enum logic [1:0] {
    CLS_RR  = 2'b00,
    CLS_LSI = 2'b01,
    CLS_BR  = 2'b10,
    CLS_RSV = 2'b11
  } ins_cls_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/fwd_elig.sv
module fwd_elig
  import fwd_pkg::*;
(
  input  logic [1:0]         cls_i,
  output logic [NUM_OPS-1:0] elig_o
);
  always_comb begin
    unique case (cls_i)
      CLS_RR:  elig_o = 2'b11;
      CLS_BR:  elig_o = 2'b11;  // both compared registers
      CLS_LSI: elig_o = 2'b01;  // base register only
      default: elig_o = 2'b00;
    endcase
  end
endmodule

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             wen_i,
  output logic             hit_o
);
  // register 0 is hardwired, never a producer
  assign hit_o = wen_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic       elig_i,
  input  logic       exm_hit_i,
  input  logic       mwb_hit_i,
  output logic [1:0] sel_o
);
  always_comb begin
    sel_o = SEL_RF;
    if (elig_i) begin
      if (exm_hit_i)      sel_o = SEL_EXM;
      else if (mwb_hit_i) sel_o = SEL_MWB;
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [1:0]       cls_i,
  input  logic [REG_W-1:0] exm_dst_i,
  input  logic             exm_wen_i,
  input  logic [REG_W-1:0] mwb_dst_i,
  input  logic             mwb_wen_i,
  output logic [1:0]       sel_a_o,
  output logic [1:0]       sel_b_o
);
  logic [NUM_OPS-1:0]            elig;
  logic [NUM_OPS-1:0][REG_W-1:0] src;
  logic [NUM_OPS-1:0][1:0]       sel;
  logic [NUM_OPS-1:0]            exm_hit;
  logic [NUM_OPS-1:0]            mwb_hit;

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;

  fwd_elig u_elig (
    .cls_i  (cls_i),
    .elig_o (elig)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_hit #(.REG_W(REG_W)) u_exm (
      .src_i (src[g]),
      .dst_i (exm_dst_i),
      .wen_i (exm_wen_i),
      .hit_o (exm_hit[g])
    );
    fwd_hit #(.REG_W(REG_W)) u_mwb (
      .src_i (src[g]),
      .dst_i (mwb_dst_i),
      .wen_i (mwb_wen_i),
      .hit_o (mwb_hit[g])
    );
    fwd_pick u_pick (
      .elig_i    (elig[g]),
      .exm_hit_i (exm_hit[g]),
      .mwb_hit_i (mwb_hit[g]),
      .sel_o     (sel[g])
    );
  end

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] src_a_i,
  input logic [REG_W-1:0] src_b_i,
  input logic [1:0]       cls_i,
  input logic [REG_W-1:0] exm_dst_i,
  input logic             exm_wen_i,
  input logic [REG_W-1:0] mwb_dst_i,
  input logic             mwb_wen_i,
  input logic [1:0]       sel_a_o,
  input logic [1:0]       sel_b_o
);
  always_comb begin
    a_r10_sel_a_legal: assert (sel_a_o != 2'b11) else $error("R10 sel_a illegal");
    a_r10_sel_b_legal: assert (sel_b_o != 2'b11) else $error("R10 sel_b illegal");
    a_r6_lsi_b_rf: assert (!(cls_i == 2'b01) || sel_b_o == 2'b00)
      else $error("R6 ld/st/imm forwarded second operand");
    a_r8_rsv_rf: assert (!(cls_i == 2'b11) || (sel_a_o == 2'b00 && sel_b_o == 2'b00))
      else $error("R8 reserved class forwarded");
    a_r3_exm_wins: assert (!(cls_i != 2'b11 && exm_wen_i && exm_dst_i != '0
                             && exm_dst_i == src_a_i) || sel_a_o == 2'b10)
      else $error("R3 exe/mem priority lost");
    a_r4_exm_off: assert (!(sel_a_o == 2'b10) || exm_wen_i)
      else $error("R4 forwarded from non-writing exe/mem");
    a_r4_mwb_off: assert (!(sel_a_o == 2'b01) || mwb_wen_i)
      else $error("R4 forwarded from non-writing mem/wb");
    a_r5_zero_a: assert (!(src_a_i == '0) || sel_a_o == 2'b00)
      else $error("R5 register 0 forwarded");
    a_r5_zero_b: assert (!(src_b_i == '0) || sel_b_o == 2'b00)
      else $error("R5 register 0 forwarded");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [REG_W-1:0] src_a, src_b, exm_dst, mwb_dst;
  logic [1:0] cls;
  logic exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_unit #(.REG_W(REG_W)) uut (
    .src_a_i(src_a), .src_b_i(src_b), .cls_i(cls),
    .exm_dst_i(exm_dst), .exm_wen_i(exm_wen),
    .mwb_dst_i(mwb_dst), .mwb_wen_i(mwb_wen),
    .sel_a_o(sel_a), .sel_b_o(sel_b)
  );

  function automatic logic [1:0] model(input logic [REG_W-1:0] s, input bit elig);
    if (!elig || s == 0) return 2'b00;
    if (exm_wen && exm_dst == s) return 2'b10;
    if (mwb_wen && mwb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic apply(input logic [1:0] c, input logic [REG_W-1:0] a, b,
                       input logic ew, input logic [REG_W-1:0] ed,
                       input logic mw, input logic [REG_W-1:0] md,
                       input string req);
    logic [1:0] ea, eb;
    @(posedge clk);
    cls = c; src_a = a; src_b = b;
    exm_wen = ew; exm_dst = ed; mwb_wen = mw; mwb_dst = md;
    @(negedge clk);
    ea = model(a, c != 2'b11);
    eb = model(b, c == 2'b00 || c == 2'b10);
    checks++;
    if (sel_a !== ea || sel_b !== eb) begin
      errors++;
      $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", req, sel_a, sel_b, ea, eb);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cls = 0; src_a = 0; src_b = 0; exm_dst = 0; mwb_dst = 0; exm_wen = 0; mwb_wen = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (sel_a !== 2'b00 || sel_b !== 2'b00) begin
      errors++;
      $display("FAIL R9 idle: %b %b expected 00 00", sel_a, sel_b);
    end
    apply(2'b00, 5'd10, 5'd12, 1, 5'd10, 0, 5'd0,  "R1");
    apply(2'b00, 5'd10, 5'd12, 1, 5'd12, 0, 5'd0,  "R1_b");
    apply(2'b00, 5'd10, 5'd12, 0, 5'd0,  1, 5'd10, "R2");
    apply(2'b00, 5'd10, 5'd10, 1, 5'd10, 1, 5'd10, "R3");
    apply(2'b00, 5'd7,  5'd8,  1, 5'd8,  1, 5'd7,  "R3_split");
    apply(2'b00, 5'd10, 5'd12, 0, 5'd10, 0, 5'd12, "R4");
    apply(2'b00, 5'd10, 5'd12, 0, 5'd10, 1, 5'd10, "R4_fallthrough");
    apply(2'b00, 5'd0,  5'd0,  1, 5'd0,  1, 5'd0,  "R5");
    apply(2'b01, 5'd3,  5'd4,  1, 5'd4,  1, 5'd4,  "R6");
    apply(2'b01, 5'd3,  5'd4,  1, 5'd3,  1, 5'd3,  "R6_base");
    apply(2'b10, 5'd5,  5'd6,  1, 5'd6,  1, 5'd5,  "R7");
    apply(2'b11, 5'd5,  5'd5,  1, 5'd5,  1, 5'd5,  "R8");
    apply(2'b00, 5'd1,  5'd2,  1, 5'd3,  1, 5'd4,  "R9");
    for (int i = 0; i < 400; i++) begin
      apply(2'($urandom), 5'($urandom % 4), 5'($urandom % 4),
            1'($urandom), 5'($urandom % 4), 1'($urandom), 5'($urandom % 4),
            "R10_random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule